// File: doc/BRIEF.md
# Multichannel Violation Counter Bank

This block keeps one error counter for each of fourteen line channels. Every channel delivers a single-cycle violation strobe, and the live counter for that channel adds one on each clock where its strobe is high. Software never reads a live counter directly. It reads a holding register instead, which is loaded from the live counter only on command, so a read always returns a frozen value while counting continues underneath.

Four command inputs come from a microprocessor-style register interface, together with a 4-bit channel-select field. The global snapshot command copies every live counter into its holding register at once. The global clear command zeroes every counter. It takes effect only after the bit has been held for a qualifying number of clock cycles, which stands for the required hold time of about one microsecond. The per-channel snapshot and per-channel clear commands act only on the channel that the select field addresses. The same select field picks which holding register drives the read port.

Top module: `viol_cnt_bank`

## Requirements
- R1: After reset, every live counter and every holding register is zero, and `rdData` reads zero for every channel code.
- R2: A channel's live counter increments by one on each clock edge where its `violStrb` bit is high. Its holding register does not change until a snapshot or clear addresses it.
- R3: A live counter saturates at 2^CNT_W-1 and never wraps to a smaller value.
- R4: The read port uses an offset-by-one code. A `chanSel` code c in 1..NUM_CH returns the holding register of channel c-1. Code 0 and every code above NUM_CH (15 in the default build) return zero.
- R5: A rising edge on `snapAllReq` copies all live counters into their holding registers on that clock edge. Keeping the bit high causes no further copies.
- R6: A rising edge on `snapOneReq` copies only the channel addressed by `chanSel`. An invalid code (0 or above NUM_CH) copies nothing.
- R7: A rising edge on `clearOneReq` zeroes the live counter and holding register of the addressed channel only. An invalid code clears nothing.
- R8: `clearAllReq` zeroes every live counter and holding register once it has been high for RST_QUAL consecutive clock edges. The clear happens once per assertion, and a shorter pulse has no effect.
- R9: When a clear and a violation strobe hit the same channel on the same edge, the clear wins and the counter ends at zero.
- R10: When a snapshot and a violation strobe hit a channel on the same edge, the holding register takes the value from before the increment, and the live counter still counts the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| violStrb | input | NUM_CH | One violation strobe per channel |
| chanSel | input | SEL_W | Channel code: 0 = none, c = channel c-1 |
| snapAllReq | input | 1 | Global snapshot control bit (acts on its rising edge) |
| snapOneReq | input | 1 | Snapshot of the selected channel (acts on its rising edge) |
| clearAllReq | input | 1 | Global clear control bit (acts after it has been held qualified) |
| clearOneReq | input | 1 | Clear of the selected channel (acts on its rising edge) |
| rdData | output | CNT_W | Holding register of the selected channel |

## Verification
The bench keeps fourteen channels and the 4-bit select field, so code 15 is a real out-of-range code. It builds the counters only 4 bits wide, which brings saturation within reach after sixteen strobes. It also sets RST_QUAL to 5 cycles, so a clear pulse one cycle too short and a pulse of exactly the qualifying length both take only a few cycles to test. Tests for a clear against a strobe and a snapshot against a strobe on the same edge cover the two ordering rules.

// File: rtl/viol_cnt_pkg.sv
package viol_cnt_pkg;
  // Single-cycle command strobes from control to datapath
  typedef struct packed {
    logic snapAll;
    logic snapOne;
    logic clearAll;
    logic clearOne;
  } cmd_t;
endpackage

// File: rtl/viol_cnt_ctrl.sv
module viol_cnt_ctrl
  import viol_cnt_pkg::*;
#(
  parameter int RST_QUAL = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic snapAllReq,
  input  logic snapOneReq,
  input  logic clearAllReq,
  input  logic clearOneReq,
  output cmd_t cmd
);
  localparam int QW = $clog2(RST_QUAL + 1);
  localparam logic [QW-1:0] QUAL_FIRE = QW'(RST_QUAL - 1);
  localparam logic [QW-1:0] QUAL_TOP  = QW'(RST_QUAL);

  logic prevSnapAll, prevSnapOne, prevClearOne;
  logic [QW-1:0] qualCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSnapAll  <= 1'b0;
      prevSnapOne  <= 1'b0;
      prevClearOne <= 1'b0;
      qualCnt      <= '0;
    end else begin
      prevSnapAll  <= snapAllReq;
      prevSnapOne  <= snapOneReq;
      prevClearOne <= clearOneReq;
      if (!clearAllReq)
        qualCnt <= '0;
      else if (qualCnt != QUAL_TOP)
        qualCnt <= qualCnt + 1'b1;
    end
  end

  always_comb begin
    cmd.snapAll  = snapAllReq  && !prevSnapAll;
    cmd.snapOne  = snapOneReq  && !prevSnapOne;
    cmd.clearOne = clearOneReq && !prevClearOne;
    cmd.clearAll = clearAllReq && (qualCnt == QUAL_FIRE);
  end

  // R5: a snapshot strobe never repeats on the next cycle
  a_r5_snap_single: assert property (@(posedge clk) disable iff (!rstN)
    cmd.snapAll |=> !cmd.snapAll);
  // R8: global clear fires only while the request is still high, and only once
  a_r8_clear_held: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |-> (clearAllReq && $past(clearAllReq)));
  a_r8_clear_once: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearAll |=> !cmd.clearAll);
endmodule

// File: rtl/viol_cnt_datapath.sv
module viol_cnt_datapath
  import viol_cnt_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  input  logic [NUM_CH-1:0] violStrb,
  input  logic [SEL_W-1:0]  chanSel,
  output logic [CNT_W-1:0]  rdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]  liveCnt [NUM_CH];
  logic [CNT_W-1:0]  holdReg [NUM_CH];
  logic [NUM_CH-1:0] chanHit, clrHit, snapHit;
  logic              selValid;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    assign chanHit[g] = (chanSel == SEL_W'(g + 1));
    assign clrHit[g]  = cmd.clearAll || (cmd.clearOne && chanHit[g]);
    assign snapHit[g] = cmd.snapAll  || (cmd.snapOne  && chanHit[g]);

    always_ff @(posedge clk) begin
      if (!rstN || clrHit[g]) begin
        liveCnt[g] <= '0;
        holdReg[g] <= '0;
      end else begin
        if (violStrb[g] && liveCnt[g] != CNT_MAX)
          liveCnt[g] <= liveCnt[g] + 1'b1;
        if (snapHit[g])
          holdReg[g] <= liveCnt[g];
      end
    end

    // R9: a clear leaves the channel at zero whatever the strobe did
    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
      clrHit[g] |=> (liveCnt[g] == '0 && holdReg[g] == '0));
    // R3: without a clear the live count never goes down
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      !clrHit[g] |=> (liveCnt[g] >= $past(liveCnt[g])));
    // R10: a snapshot captures the value from before the edge
    a_r10_snap_pre: assert property (@(posedge clk) disable iff (!rstN)
      (snapHit[g] && !clrHit[g]) |=> (holdReg[g] == $past(liveCnt[g])));
    // R2: the holding register moves only on a command
    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
      (!snapHit[g] && !clrHit[g]) |=> $stable(holdReg[g]));
  end

  assign selValid = |chanHit;

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++)
      rdData = rdData | (holdReg[i] & {CNT_W{chanHit[i]}});
  end

  // R4: codes that select no channel read zero
  a_r4_none_zero: assert property (@(posedge clk) disable iff (!rstN)
    !selValid |-> (rdData == '0));
endmodule

// File: rtl/viol_cnt_bank.sv
module viol_cnt_bank
  import viol_cnt_pkg::*;
#(
  parameter int NUM_CH   = 14,
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 4,
  parameter int RST_QUAL = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] violStrb,
  input  logic [SEL_W-1:0]  chanSel,
  input  logic              snapAllReq,
  input  logic              snapOneReq,
  input  logic              clearAllReq,
  input  logic              clearOneReq,
  output logic [CNT_W-1:0]  rdData
);
  cmd_t cmd;

  viol_cnt_ctrl #(.RST_QUAL(RST_QUAL)) uCtrl (
    .clk(clk), .rstN(rstN),
    .snapAllReq(snapAllReq), .snapOneReq(snapOneReq),
    .clearAllReq(clearAllReq), .clearOneReq(clearOneReq),
    .cmd(cmd)
  );

  viol_cnt_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .violStrb(violStrb), .chanSel(chanSel), .rdData(rdData)
  );
endmodule

// File: tb/viol_cnt_bank_test.sv
module viol_cnt_bank_test;
  localparam int NCH  = 14;
  localparam int CW   = 4;
  localparam int SW   = 4;
  localparam int QUAL = 5;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN;
  logic [NCH-1:0] violStrb;
  logic [SW-1:0]  chanSel;
  logic snapAllReq, snapOneReq, clearAllReq, clearOneReq;
  logic [CW-1:0]  rdData;

  int nRun = 0, nFail = 0;
  int expLive [NCH];
  int expHold [NCH];

  always #5 clk = ~clk;

  viol_cnt_bank #(.NUM_CH(NCH), .CNT_W(CW), .SEL_W(SW), .RST_QUAL(QUAL)) uut (
    .clk(clk), .rstN(rstN), .violStrb(violStrb), .chanSel(chanSel),
    .snapAllReq(snapAllReq), .snapOneReq(snapOneReq),
    .clearAllReq(clearAllReq), .clearOneReq(clearOneReq), .rdData(rdData)
  );

  task automatic chk(string req, int got, int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic readChk(string req, int ch);
    chanSel = SW'(ch + 1);
    #1;
    chk(req, int'(rdData), expHold[ch]);
  endtask

  task automatic bump(int ch);
    if (expLive[ch] < MAXV) expLive[ch]++;
  endtask

  task automatic pulse(int ch, int n);
    for (int k = 0; k < n; k++) begin
      violStrb[ch] = 1'b1;
      @(negedge clk);
      bump(ch);
    end
    violStrb[ch] = 1'b0;
  endtask

  task automatic snapAll();
    snapAllReq = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) expHold[c] = expLive[c];
    snapAllReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) readChk("R1 reset", c);
    chanSel = '0; #1; chk("R1 reset code0", int'(rdData), 0);
  endtask

  task automatic t_count();
    pulse(0, 3);
    pulse(5, 7);
    readChk("R2 hold frozen before snapshot", 0);
    snapAll();
    readChk("R2/R5 ch0", 0);
    readChk("R2/R5 ch5", 5);
    readChk("R5 ch1 untouched", 1);
  endtask

  task automatic t_snapHeld();
    snapAllReq = 1'b1;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) expHold[c] = expLive[c];
    pulse(0, 2);
    @(negedge clk);
    readChk("R5 held bit no repeat", 0);
    snapAllReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sel();
    chanSel = 4'd0;  #1; chk("R4 code 0", int'(rdData), 0);
    chanSel = 4'd15; #1; chk("R4 code 15", int'(rdData), 0);
    pulse(13, 4);
    snapAll();
    chanSel = 4'd14; #1; chk("R4 code 14 -> ch13", int'(rdData), 4);
  endtask

  task automatic t_snapOne();
    pulse(5, 1);
    chanSel = 4'd1; snapOneReq = 1'b1;
    @(negedge clk);
    expHold[0] = expLive[0];
    snapOneReq = 1'b0;
    @(negedge clk);
    readChk("R6 selected ch0", 0);
    readChk("R6 ch5 not copied", 5);
    chanSel = 4'd0; snapOneReq = 1'b1;
    @(negedge clk);
    snapOneReq = 1'b0;
    @(negedge clk);
    readChk("R6 code 0 copies nothing", 5);
  endtask

  task automatic t_sat();
    pulse(2, 20);
    snapAll();
    readChk("R3 saturate", 2);
    chk("R3 saturate value", expHold[2], MAXV);
  endtask

  task automatic t_clearOne();
    chanSel = 4'd3; clearOneReq = 1'b1;
    @(negedge clk);
    expLive[2] = 0; expHold[2] = 0;
    clearOneReq = 1'b0;
    @(negedge clk);
    readChk("R7 hold cleared", 2);
    readChk("R7 neighbour kept", 0);
    chanSel = 4'd15; clearOneReq = 1'b1;
    @(negedge clk);
    clearOneReq = 1'b0;
    @(negedge clk);
    snapAll();
    readChk("R7 ch2 live cleared", 2);
    readChk("R7 code 15 clears nothing", 5);
  endtask

  task automatic t_clearRace();
    pulse(3, 3);
    chanSel = 4'd4; clearOneReq = 1'b1; violStrb[3] = 1'b1;
    @(negedge clk);
    expLive[3] = 0; expHold[3] = 0;
    clearOneReq = 1'b0; violStrb[3] = 1'b0;
    @(negedge clk);
    snapAll();
    readChk("R9 clear beats strobe", 3);
  endtask

  task automatic t_snapRace();
    pulse(4, 2);
    chanSel = 4'd5; snapOneReq = 1'b1; violStrb[4] = 1'b1;
    @(negedge clk);
    expHold[4] = expLive[4];
    bump(4);
    snapOneReq = 1'b0; violStrb[4] = 1'b0;
    @(negedge clk);
    readChk("R10 snapshot takes pre value", 4);
    chk("R10 pre value", expHold[4], 2);
    snapAll();
    readChk("R10 strobe counted live", 4);
  endtask

  task automatic t_clearAll();
    clearAllReq = 1'b1;
    for (int k = 0; k < QUAL - 1; k++) @(negedge clk);
    clearAllReq = 1'b0;
    @(negedge clk);
    readChk("R8 short pulse no clear", 0);
    clearAllReq = 1'b1;
    for (int k = 0; k < QUAL; k++) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin expLive[c] = 0; expHold[c] = 0; end
    readChk("R8 qualified clear hold ch0", 0);
    pulse(1, 2);
    @(negedge clk);
    clearAllReq = 1'b0;
    @(negedge clk);
    snapAll();
    readChk("R8 clear fires once ch1", 1);
    readChk("R8 ch5 cleared", 5);
    readChk("R8 ch13 cleared", 13);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin expLive[c] = 0; expHold[c] = 0; end
    rstN = 1'b0; violStrb = '0; chanSel = '0;
    snapAllReq = 1'b0; snapOneReq = 1'b0; clearAllReq = 1'b0; clearOneReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_snapHeld();
    t_sel();
    t_snapOne();
    t_sat();
    t_clearOne();
    t_clearRace();
    t_snapRace();
    t_clearAll();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule